// File: doc/BRIEF.md
# Memory Access Fault Checker with Exception Capture

This block sits beside the load/store and fetch path of a 32-bit core. For every access that the core presents, it judges whether the access must trap. It uses the virtual address, the kind of access (fetch, read or write), the operand size, the current privilege level and the result of a translation lookup that has already been done elsewhere. That result gives hit, way, a two-bit protection code and a page-modified flag. Four causes can make an access trap: a misaligned or user-forbidden address, a protection violation, or the first store to a page that has not yet been written. Each cause has its own event code, and all of them branch to one common handler entry.

When an access traps, the block raises a one-cycle fault pulse. On that same clock edge it records the exception state:
- the faulting address;
- for translation-related causes, the page number together with the current address-space identifier and the way that matched;
- the interrupted program counter and status word.

It then sets the privileged, register-bank and block-exceptions bits of the status word it holds. The privilege level used by the checks is the privileged bit of that held status word. The core reloads the status word through a load strobe, for example when it returns from a handler.

Top module: `acc_fault_unit`

## Requirements
- R1: After a synchronous active-low reset, `fault` is 0, `eventCode` and every capture register read 0, and `statusWord` reads 0x5000_0000 (privileged bit 30 and block bit 28 set).
- R2: An access with `reqValid`=1 that traps produces `fault`=1 for exactly the one cycle after the request edge. An access that does not trap, or any cycle without `reqValid`, leaves `fault` at 0 and leaves every capture register unchanged. A lookup miss (`tlbHit`=0) on an aligned, permitted address does not trap.
- R3: On a hit, `tlbPr` grants rights as follows. 00: privileged read only, and no user access. 01: privileged read/write, and no user access. 10: read only in both modes. 11: read/write in both modes. Fetches count as reads. `reqKind` is 00 for fetch, 01 for read and 10 for write. User mode means bit 30 of `statusWord` is 0.
- R4: A protection violation reports event code 0x0A0 for a fetch or read and 0x0C0 for a write.
- R5: A write that hits an entry with `tlbDirty`=0 and that the protection code allows reports event code 0x080. With `tlbDirty`=1 it does not trap.
- R6: An address error is raised in these cases:
  - a fetch with address bit 0 set;
  - a word access (`reqSize`=01) with bit 0 set;
  - a longword access (`reqSize`=10) with either of bits 1:0 set;
  - a user-mode access with address bit 31 set.
  
  Byte accesses (`reqSize`=00) have no alignment rule. The event code is 0x0E0 for a fetch or read and 0x100 for a write, and it does not depend on `tlbHit`.
- R7: Only the cause with the highest priority is reported. An address error ranks above a protection violation, and a protection violation ranks above a first write.
- R8: Every trap loads `faultAddr` with the full address. A protection or first-write trap also loads `pageHi` with {address[31:10], 2'b00, `curAsid`} and `wayField` with `tlbWay`. An address error leaves `pageHi` and `wayField` unchanged.
- R9: On a trap, `savedPc` takes `curPc` and `savedStatus` takes the status word held before the trap. `statusWord` gets bits 30, 29 and 28 set and keeps all its other bits. `excVector` always equals `vectorBase` + 0x100.
- R10: `srLoad`=1 writes `srLoadVal` into `statusWord` on the next edge. If an access traps on the same edge, the trap update wins and the load is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Synchronous active-low reset |
| reqValid | input | 1 | Access present this cycle |
| reqKind | input | 2 | 00 fetch, 01 read, 10 write |
| reqSize | input | 2 | 00 byte, 01 word, 10 longword |
| reqAddr | input | 32 | Virtual address of the access |
| tlbHit | input | 1 | Lookup found a matching entry |
| tlbWay | input | 2 | Way of the matching entry |
| tlbPr | input | 2 | Protection code of the entry |
| tlbDirty | input | 1 | Page already written |
| curAsid | input | 8 | Current address-space identifier |
| curPc | input | 32 | Program counter of the access |
| vectorBase | input | 32 | Handler table base |
| srLoad | input | 1 | Load the status word |
| srLoadVal | input | 32 | Value for the status word |
| fault | output | 1 | One-cycle trap pulse |
| eventCode | output | 12 | Code of the last trap |
| excVector | output | 32 | Handler entry address |
| faultAddr | output | 32 | Address of the last trap |
| pageHi | output | 32 | Page number and identifier of the last translation trap |
| wayField | output | 2 | Way of the last translation trap |
| savedPc | output | 32 | Program counter saved at trap |
| savedStatus | output | 32 | Status word saved at trap |
| statusWord | output | 32 | Current status word |

## Verification
Some properties are checked on every cycle:
- every trap pulse follows a valid request;
- the reported code is always one of the five legal values;
- a user access to the upper half of the address space always reports an address-error code;
- the three status bits are set after every trap;
- the saved state never moves without a trap;
- an address error never disturbs the page and way fields.

Only the directed scenarios can show the rest. These are the exact cells of the protection table in both modes, the alignment rule per size, the ordering of simultaneous causes, the exact captured values, and how a status load collides with a trap.

// File: rtl/afu_pkg.sv
package afu_pkg;
  localparam int CODE_W = 12;

  typedef enum logic [1:0] {
    KIND_FETCH = 2'b00,
    KIND_READ  = 2'b01,
    KIND_WRITE = 2'b10
  } accKind_e;

  typedef enum logic [1:0] {
    SIZE_BYTE = 2'b00,
    SIZE_WORD = 2'b01,
    SIZE_LONG = 2'b10
  } accSize_e;

  localparam logic [CODE_W-1:0] CODE_FIRST_WR = 12'h080;
  localparam logic [CODE_W-1:0] CODE_PROT_RD  = 12'h0A0;
  localparam logic [CODE_W-1:0] CODE_PROT_WR  = 12'h0C0;
  localparam logic [CODE_W-1:0] CODE_ADDR_RD  = 12'h0E0;
  localparam logic [CODE_W-1:0] CODE_ADDR_WR  = 12'h100;

  localparam int SR_MD_BIT = 30;
  localparam int SR_RB_BIT = 29;
  localparam int SR_BL_BIT = 28;

  typedef struct packed {
    logic capAny;
    logic capTlb;
  } capStrobe_t;
endpackage

// File: rtl/afu_control.sv
module afu_control
  import afu_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic [1:0]        reqKind,
  input  logic [1:0]        reqSize,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic              userMode,
  input  logic              tlbHit,
  input  logic [1:0]        tlbPr,
  input  logic              tlbDirty,
  output capStrobe_t        strobes,
  output logic              fault,
  output logic [CODE_W-1:0] eventCode
);
  logic isWrite;
  logic misalign;
  logic addrErr;
  logic protErr;
  logic firstWr;
  logic trapNow;
  logic [CODE_W-1:0] codeNext;

  always_comb begin
    isWrite  = (reqKind == KIND_WRITE);
    misalign = 1'b0;
    if (reqKind == KIND_FETCH) begin
      misalign = reqAddr[0];
    end else begin
      case (reqSize)
        SIZE_WORD: misalign = reqAddr[0];
        SIZE_LONG: misalign = |reqAddr[1:0];
        default:   misalign = 1'b0;
      endcase
    end
    addrErr = misalign || (userMode && reqAddr[ADDR_W-1]);
    protErr = tlbHit && ((userMode && !tlbPr[1]) || (isWrite && !tlbPr[0]));
    firstWr = tlbHit && isWrite && !tlbDirty;

    codeNext = CODE_FIRST_WR;
    if (addrErr)      codeNext = isWrite ? CODE_ADDR_WR : CODE_ADDR_RD;
    else if (protErr) codeNext = isWrite ? CODE_PROT_WR : CODE_PROT_RD;

    trapNow        = reqValid && (addrErr || protErr || firstWr);
    strobes.capAny = trapNow;
    strobes.capTlb = trapNow && !addrErr;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      fault     <= 1'b0;
      eventCode <= '0;
    end else begin
      fault <= trapNow;
      if (trapNow) eventCode <= codeNext;
    end
  end

  a_r2_fault_needs_request: assert property (@(posedge clk) disable iff (!rstN)
    fault |-> $past(reqValid));

  a_r7_code_legal: assert property (@(posedge clk) disable iff (!rstN)
    fault |-> (eventCode == CODE_FIRST_WR || eventCode == CODE_PROT_RD ||
               eventCode == CODE_PROT_WR  || eventCode == CODE_ADDR_RD ||
               eventCode == CODE_ADDR_WR));

  a_r6_user_upper_half: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && userMode && reqAddr[ADDR_W-1]) |=>
      (fault && (eventCode == CODE_ADDR_RD || eventCode == CODE_ADDR_WR)));
endmodule

// File: rtl/afu_datapath.sv
module afu_datapath
  import afu_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int ASID_W     = 8,
  parameter int WAY_W      = 2,
  parameter int PAGE_SHIFT = 10
) (
  input  logic              clk,
  input  logic              rstN,
  input  capStrobe_t        strobes,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [ASID_W-1:0] curAsid,
  input  logic [WAY_W-1:0]  tlbWay,
  input  logic [ADDR_W-1:0] curPc,
  input  logic              srLoad,
  input  logic [ADDR_W-1:0] srLoadVal,
  output logic [ADDR_W-1:0] faultAddr,
  output logic [ADDR_W-1:0] pageHi,
  output logic [WAY_W-1:0]  wayField,
  output logic [ADDR_W-1:0] savedPc,
  output logic [ADDR_W-1:0] savedStatus,
  output logic [ADDR_W-1:0] statusWord
);
  localparam int GAP_W = PAGE_SHIFT - ASID_W;
  localparam logic [ADDR_W-1:0] TRAP_BITS =
    (ADDR_W'(1) << SR_MD_BIT) | (ADDR_W'(1) << SR_RB_BIT) | (ADDR_W'(1) << SR_BL_BIT);
  localparam logic [ADDR_W-1:0] RESET_SR =
    (ADDR_W'(1) << SR_MD_BIT) | (ADDR_W'(1) << SR_BL_BIT);

  logic [ADDR_W-1:0] pageNext;

  generate
    if (GAP_W > 0) begin : g_gap
      assign pageNext = {reqAddr[ADDR_W-1:PAGE_SHIFT], {GAP_W{1'b0}}, curAsid};
    end else begin : g_nogap
      assign pageNext = {reqAddr[ADDR_W-1:PAGE_SHIFT], curAsid[PAGE_SHIFT-1:0]};
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rstN) begin
      faultAddr   <= '0;
      savedPc     <= '0;
      savedStatus <= '0;
      statusWord  <= RESET_SR;
    end else if (strobes.capAny) begin
      faultAddr   <= reqAddr;
      savedPc     <= curPc;
      savedStatus <= statusWord;
      statusWord  <= statusWord | TRAP_BITS;
    end else if (srLoad) begin
      statusWord  <= srLoadVal;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pageHi   <= '0;
      wayField <= '0;
    end else if (strobes.capTlb) begin
      pageHi   <= pageNext;
      wayField <= tlbWay;
    end
  end

  a_r9_status_bits_set: assert property (@(posedge clk) disable iff (!rstN)
    strobes.capAny |=> (statusWord[SR_MD_BIT] && statusWord[SR_RB_BIT] && statusWord[SR_BL_BIT]));

  a_r2_hold_without_trap: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.capAny |=> ($stable(savedPc) && $stable(faultAddr) && $stable(savedStatus)));

  a_r8_addr_err_keeps_tlb: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.capAny && !strobes.capTlb) |=> ($stable(pageHi) && $stable(wayField)));
endmodule

// File: rtl/acc_fault_unit.sv
module acc_fault_unit
  import afu_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int ASID_W     = 8,
  parameter int WAY_W      = 2,
  parameter int PAGE_SHIFT = 10,
  parameter int VEC_OFS    = 'h100
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic [1:0]        reqKind,
  input  logic [1:0]        reqSize,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic              tlbHit,
  input  logic [WAY_W-1:0]  tlbWay,
  input  logic [1:0]        tlbPr,
  input  logic              tlbDirty,
  input  logic [ASID_W-1:0] curAsid,
  input  logic [ADDR_W-1:0] curPc,
  input  logic [ADDR_W-1:0] vectorBase,
  input  logic              srLoad,
  input  logic [ADDR_W-1:0] srLoadVal,
  output logic              fault,
  output logic [CODE_W-1:0] eventCode,
  output logic [ADDR_W-1:0] excVector,
  output logic [ADDR_W-1:0] faultAddr,
  output logic [ADDR_W-1:0] pageHi,
  output logic [WAY_W-1:0]  wayField,
  output logic [ADDR_W-1:0] savedPc,
  output logic [ADDR_W-1:0] savedStatus,
  output logic [ADDR_W-1:0] statusWord
);
  capStrobe_t strobes;
  logic       userMode;

  assign userMode  = !statusWord[SR_MD_BIT];
  assign excVector = vectorBase + ADDR_W'(VEC_OFS);

  afu_control #(.ADDR_W(ADDR_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqKind(reqKind),
    .reqSize(reqSize), .reqAddr(reqAddr), .userMode(userMode),
    .tlbHit(tlbHit), .tlbPr(tlbPr), .tlbDirty(tlbDirty),
    .strobes(strobes), .fault(fault), .eventCode(eventCode)
  );

  afu_datapath #(.ADDR_W(ADDR_W), .ASID_W(ASID_W), .WAY_W(WAY_W),
                 .PAGE_SHIFT(PAGE_SHIFT)) u_dp (
    .clk(clk), .rstN(rstN), .strobes(strobes), .reqAddr(reqAddr),
    .curAsid(curAsid), .tlbWay(tlbWay), .curPc(curPc), .srLoad(srLoad),
    .srLoadVal(srLoadVal), .faultAddr(faultAddr), .pageHi(pageHi),
    .wayField(wayField), .savedPc(savedPc), .savedStatus(savedStatus),
    .statusWord(statusWord)
  );
endmodule

// File: tb/acc_fault_unit_tb.sv
module acc_fault_unit_tb;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0;
  logic [1:0]  reqKind = 2'b01;
  logic [1:0]  reqSize = 2'b10;
  logic [31:0] reqAddr = '0;
  logic        tlbHit = 1'b0;
  logic [1:0]  tlbWay = '0;
  logic [1:0]  tlbPr = '0;
  logic        tlbDirty = 1'b1;
  logic [7:0]  curAsid = 8'h00;
  logic [31:0] curPc = '0;
  logic [31:0] vectorBase = 32'h0000_4000;
  logic        srLoad = 1'b0;
  logic [31:0] srLoadVal = '0;
  logic        fault;
  logic [11:0] eventCode;
  logic [31:0] excVector, faultAddr, pageHi, savedPc, savedStatus, statusWord;
  logic [1:0]  wayField;

  int total = 0;
  int bad = 0;

  acc_fault_unit u_dut (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqKind(reqKind),
    .reqSize(reqSize), .reqAddr(reqAddr), .tlbHit(tlbHit), .tlbWay(tlbWay),
    .tlbPr(tlbPr), .tlbDirty(tlbDirty), .curAsid(curAsid), .curPc(curPc),
    .vectorBase(vectorBase), .srLoad(srLoad), .srLoadVal(srLoadVal),
    .fault(fault), .eventCode(eventCode), .excVector(excVector),
    .faultAddr(faultAddr), .pageHi(pageHi), .wayField(wayField),
    .savedPc(savedPc), .savedStatus(savedStatus), .statusWord(statusWord)
  );

  always #5 clk = ~clk;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic issue(input logic [1:0] kind, input logic [1:0] size, input logic [31:0] addr,
                       input logic hit, input logic [1:0] way, input logic [1:0] pr,
                       input logic dirty);
    @(negedge clk);
    reqKind = kind; reqSize = size; reqAddr = addr; tlbHit = hit;
    tlbWay = way; tlbPr = pr; tlbDirty = dirty; reqValid = 1'b1;
    @(negedge clk);
    reqValid = 1'b0;
  endtask

  task automatic setSr(input logic [31:0] val);
    @(negedge clk);
    srLoad = 1'b1; srLoadVal = val;
    @(negedge clk);
    srLoad = 1'b0;
  endtask

  task automatic t_reset;
    chk("R1 fault", {31'b0, fault}, 0);
    chk("R1 code", {20'b0, eventCode}, 0);
    chk("R1 faultAddr", faultAddr, 0);
    chk("R1 savedPc", savedPc, 0);
    chk("R1 pageHi", pageHi, 0);
    chk("R1 statusWord", statusWord, 32'h5000_0000);
  endtask

  task automatic t_clean;
    issue(2'b01, 2'b10, 32'h0000_1000, 1'b1, 2'd1, 2'b00, 1'b1);
    chk("R2 clean read no fault", {31'b0, fault}, 0);
    chk("R2 clean read no capture", faultAddr, 0);
    issue(2'b10, 2'b10, 32'h0000_2000, 1'b0, 2'd2, 2'b00, 1'b0);
    chk("R2 miss no fault", {31'b0, fault}, 0);
    chk("R2 miss no capture", savedPc, 0);
  endtask

  task automatic t_protTable;
    for (int m = 0; m < 2; m++) begin
      for (int p = 0; p < 4; p++) begin
        for (int w = 0; w < 2; w++) begin
          logic allow;
          logic [1:0] pr;
          pr = 2'(p);
          allow = (m == 1) ? pr[1] : 1'b1;
          if (w == 1) allow = allow && pr[0];
          setSr(m == 1 ? 32'h0000_0000 : 32'h4000_0000);
          issue(w == 1 ? 2'b10 : 2'b01, 2'b10, 32'h0000_3000, 1'b1, 2'd0, pr, 1'b1);
          chk($sformatf("R3 table m%0d pr%0d w%0d fault", m, p, w), {31'b0, fault}, {31'b0, !allow});
          if (!allow)
            chk($sformatf("R4 table m%0d pr%0d w%0d code", m, p, w), {20'b0, eventCode},
                w == 1 ? 32'h0C0 : 32'h0A0);
        end
      end
    end
    setSr(32'h0000_0000);
    issue(2'b00, 2'b10, 32'h0000_3004, 1'b1, 2'd0, 2'b01, 1'b1);
    chk("R4 user fetch prot code", {20'b0, eventCode}, 32'h0A0);
  endtask

  task automatic t_firstWrite;
    setSr(32'h4000_0000);
    curAsid = 8'h5A;
    issue(2'b10, 2'b10, 32'hABCD_E7F4, 1'b1, 2'd3, 2'b01, 1'b0);
    chk("R5 first write fault", {31'b0, fault}, 1);
    chk("R5 first write code", {20'b0, eventCode}, 32'h080);
    chk("R8 pageHi", pageHi, {22'h2AF379, 2'b00, 8'h5A});
    chk("R8 wayField", {30'b0, wayField}, 3);
    chk("R8 faultAddr", faultAddr, 32'hABCD_E7F4);
    setSr(32'h4000_0000);
    issue(2'b10, 2'b10, 32'h0000_5000, 1'b1, 2'd1, 2'b01, 1'b1);
    chk("R5 dirty page no fault", {31'b0, fault}, 0);
  endtask

  task automatic t_addrErr;
    setSr(32'h4000_0000);
    issue(2'b00, 2'b10, 32'h0000_6001, 1'b0, 2'd0, 2'b11, 1'b1);
    chk("R6 odd fetch", {20'b0, eventCode}, 32'h0E0);
    chk("R8 addr err keeps pageHi", pageHi, {22'h2AF379, 2'b00, 8'h5A});
    chk("R8 addr err keeps way", {30'b0, wayField}, 3);
    chk("R8 addr err faultAddr", faultAddr, 32'h0000_6001);
    issue(2'b10, 2'b01, 32'h0000_6003, 1'b1, 2'd1, 2'b11, 1'b1);
    chk("R6 odd word write", {20'b0, eventCode}, 32'h100);
    chk("R8 addr err hit keeps way", {30'b0, wayField}, 3);
    issue(2'b01, 2'b10, 32'h0000_6002, 1'b1, 2'd0, 2'b11, 1'b1);
    chk("R6 long at 4n+2", {20'b0, eventCode}, 32'h0E0);
    issue(2'b01, 2'b01, 32'h0000_6002, 1'b1, 2'd0, 2'b11, 1'b1);
    chk("R6 word at 4n+2 ok", {31'b0, fault}, 0);
    issue(2'b01, 2'b00, 32'h0000_6003, 1'b1, 2'd0, 2'b11, 1'b1);
    chk("R6 odd byte ok", {31'b0, fault}, 0);
    issue(2'b01, 2'b10, 32'h8000_0000, 1'b1, 2'd0, 2'b11, 1'b1);
    chk("R6 privileged upper ok", {31'b0, fault}, 0);
    setSr(32'h0000_0000);
    issue(2'b01, 2'b10, 32'h8000_0000, 1'b1, 2'd0, 2'b11, 1'b1);
    chk("R6 user upper fault", {31'b0, fault}, 1);
    chk("R6 user upper code", {20'b0, eventCode}, 32'h0E0);
  endtask

  task automatic t_priority;
    setSr(32'h0000_0000);
    issue(2'b10, 2'b10, 32'h0000_7002, 1'b1, 2'd2, 2'b00, 1'b0);
    chk("R7 addr over prot", {20'b0, eventCode}, 32'h100);
    setSr(32'h0000_0000);
    issue(2'b10, 2'b10, 32'h0000_7000, 1'b1, 2'd2, 2'b10, 1'b0);
    chk("R7 prot over first write", {20'b0, eventCode}, 32'h0C0);
    chk("R8 prot way", {30'b0, wayField}, 2);
  endtask

  task automatic t_capture;
    setSr(32'h0000_00F0);
    curPc = 32'h0000_1234;
    issue(2'b01, 2'b10, 32'h0000_8000, 1'b1, 2'd1, 2'b00, 1'b1);
    chk("R9 savedPc", savedPc, 32'h0000_1234);
    chk("R9 savedStatus", savedStatus, 32'h0000_00F0);
    chk("R9 statusWord", statusWord, 32'h7000_00F0);
    chk("R9 vector", excVector, 32'h0000_4100);
    @(negedge clk);
    chk("R2 pulse one cycle", {31'b0, fault}, 0);
  endtask

  task automatic t_srLoad;
    setSr(32'h0000_000C);
    chk("R10 load alone", statusWord, 32'h0000_000C);
    @(negedge clk);
    srLoad = 1'b1; srLoadVal = 32'h0000_0003;
    reqKind = 2'b00; reqSize = 2'b10; reqAddr = 32'h0000_9001; tlbHit = 1'b0;
    reqValid = 1'b1;
    @(negedge clk);
    srLoad = 1'b0; reqValid = 1'b0;
    chk("R10 trap wins status", statusWord, 32'h7000_000C);
    chk("R10 trap saves old status", savedStatus, 32'h0000_000C);
  endtask

  initial begin
    #(200000 * 10);
    bad++;
    total++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    t_reset;
    t_clean;
    t_protTable;
    t_firstWrite;
    t_addrErr;
    t_priority;
    t_capture;
    t_srLoad;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule